// File: doc/BRIEF.md
# Supervisor reset pulse stretcher

This block produces the system reset of a chip from three requests. The first is a digital power-fail flag from an external supply comparator. The second is a manual pushbutton, which is active low. The third is a single-cycle watchdog timeout pulse. Reset is asserted while any request is present. After the last request has gone away, reset stays asserted for a fixed minimum hold time. The block drives an active-high reset and an active-low reset that always agree. It also drives a status line that separates "a request is present now" from "the post-release hold is still running".

Both asynchronous inputs (power-fail and pushbutton) pass through a two-flop synchroniser. Each is then qualified by counting timebase ticks while the synchronised level stays in its active state. The pushbutton is counted on a millisecond tick, so contact bounce and short presses are rejected. The power-fail flag is counted on a microsecond tick, so supply glitches shorter than the filter window are ignored. A single hold counter, also driven by the millisecond tick, stretches the reset. Any request reloads it to its full value. The synchronous reset of the block itself puts the outputs in the asserted state and starts a full hold.

Top module: `sup_reset_stretch`

## Requirements
- R1: While `rst` is high, `sys_rst` is 1, `sys_rst_n` is 0 and `rst_active` is 0. After `rst` falls with no request present, reset stays asserted for 250 to 251 millisecond ticks (plus a few cycles of pipeline).
- R2: Reset is asserted while `pwr_fail` is high (qualified), and stays asserted until the hold time has elapsed after `pwr_fail` has returned low.
- R3: Once the last request has cleared, `sys_rst` stays 1 for at least 250 full millisecond tick periods. It falls no later than 251 periods plus 8 clock cycles after the request was removed.
- R4: A request that arrives while the hold counter is running reloads the counter, so the release is timed from the latest request.
- R5: The pushbutton is recognised only after `btn_n` has stayed low across 21 millisecond ticks (strictly more than 20 ms). A press that spans 19 ticks causes no reset, and a press that spans 21 ticks does.
- R6: After a recognised press, reset stays asserted until the hold time has elapsed after `btn_n` returns high.
- R7: A one-cycle high pulse on `wdog_to` asserts reset and starts a full hold.
- R8: A `pwr_fail` pulse that spans fewer than 3 microsecond ticks (any pulse shorter than 2 µs) causes no reset. A pulse spanning 3 ticks does.
- R9: `sys_rst_n` is the exact complement of `sys_rst` in every cycle.
- R10: `rst_active` is 1 while a qualified request is present. It is 0 during the post-release hold, while `sys_rst` is still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous block reset, active high; asserts the reset outputs |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| tick_us | input | 1 | One-cycle strobe about every microsecond |
| pwr_fail | input | 1 | Asynchronous power-fail flag from the comparator, high = supply bad |
| btn_n | input | 1 | Asynchronous manual reset button, low = pressed |
| wdog_to | input | 1 | Synchronous one-cycle watchdog timeout pulse |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |
| rst_active | output | 1 | A qualified reset request is currently present |

## Verification
The main function is exercised with each request kind on its own:
- A long power-fail level shows level merging.
- A single watchdog pulse shows pulse stretching.
- A short and a long button press show the release timing after a level.

Two watchdog pulses spaced inside one hold window separate a reloading counter from one that only starts once. Presses of 19 and 21 ms, and power-fail pulses of 1 and 3 µs, bracket each qualification threshold from both sides. Every release is compared against a window whose lower edge is the full 250 ms. A long press with a mid-press probe of the status line tells the request phase apart from the hold phase.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // Counter width able to hold the value n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // Qualified request set seen by the hold stage.
   typedef struct packed {
      logic pwr;
      logic btn;
      logic wdog;
   } req_set_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          IDLE_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 1) begin : g_bad_stages
      $error("sup_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic ff;
      always_ff @(posedge clk) begin
         if (rst) ff <= IDLE_VAL;
         else     ff <= d_async;
      end
      assign q_sync = ff;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (rst) chain <= {STAGES{IDLE_VAL}};
         else     chain <= {chain[STAGES-2:0], d_async};
      end
      assign q_sync = chain[STAGES-1];
   end

endmodule

// File: rtl/sup_tick_qual.sv
module sup_tick_qual #(
   parameter int unsigned THRESH     = 21,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic level_i,
   output logic qual_o
);
   import sup_pkg::*;

   localparam int unsigned CW = cnt_width(THRESH);
   localparam logic [CW-1:0] THR_C = CW'(THRESH);

   if (THRESH < 1) begin : g_bad_thresh
      $error("sup_tick_qual: THRESH must be at least 1");
   end

   logic act;
   if (ACTIVE_LOW) begin : g_low
      assign act = ~level_i;
   end else begin : g_high
      assign act = level_i;
   end

   logic [CW-1:0] cnt;
   always_ff @(posedge clk) begin
      if (rst || !act)                 cnt <= '0;
      else if (tick_i && cnt != THR_C) cnt <= cnt + 1'b1;
   end

   assign qual_o = (cnt == THR_C);

   // a request only becomes qualified on a timebase tick
   assert_qual_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(qual_o) |-> $past(tick_i) && $past(act));

   // qualification is dropped as soon as the level goes inactive
   assert_drop_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !act |=> !qual_o);

endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
   parameter int unsigned HOLD_TICKS = 250
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic req_i,
   output logic busy_o
);
   import sup_pkg::*;

   // One spare tick so the hold lasts at least HOLD_TICKS full periods.
   localparam int unsigned RELOAD = HOLD_TICKS + 1;
   localparam int unsigned CW     = cnt_width(RELOAD);
   localparam logic [CW-1:0] RELOAD_C = CW'(RELOAD);

   if (HOLD_TICKS < 1) begin : g_bad_hold
      $error("sup_hold: HOLD_TICKS must be at least 1");
   end

   logic [CW-1:0] cnt;
   always_ff @(posedge clk) begin
      if (rst || req_i)               cnt <= RELOAD_C;
      else if (tick_i && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign busy_o = (cnt != '0);

   // hold ends only on a tick with no pending request
   assert_end_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_o) |-> $past(tick_i) && !$past(req_i));

   // a request always leaves the counter running
   assert_req_restarts_R4: assert property (@(posedge clk) disable iff (rst)
      req_i |=> busy_o);

endmodule

// File: rtl/sup_reset_stretch.sv
module sup_reset_stretch #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned BTN_QUAL_MS  = 20,
   parameter int unsigned PF_GLITCH_US = 2,
   parameter int unsigned HOLD_MS      = 250
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_ms,
   input  logic tick_us,
   input  logic pwr_fail,
   input  logic btn_n,
   input  logic wdog_to,
   output logic sys_rst,
   output logic sys_rst_n,
   output logic rst_active
);
   import sup_pkg::*;

   // Thresholds are one above the rejected duration, so a level that
   // spans exactly the rejected number of ticks is never accepted.
   localparam int unsigned BTN_THRESH = BTN_QUAL_MS + 1;
   localparam int unsigned PF_THRESH  = PF_GLITCH_US + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sup_reset_stretch: SYNC_STAGES must be at least 2");
   end

   logic pf_s, btn_s;

   sup_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b0)) u_pf_sync (
      .clk(clk), .rst(rst), .d_async(pwr_fail), .q_sync(pf_s));

   sup_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_btn_sync (
      .clk(clk), .rst(rst), .d_async(btn_n), .q_sync(btn_s));

   req_set_t req;

   sup_tick_qual #(.THRESH(PF_THRESH), .ACTIVE_LOW(1'b0)) u_pf_qual (
      .clk(clk), .rst(rst), .tick_i(tick_us), .level_i(pf_s),
      .qual_o(req.pwr));

   sup_tick_qual #(.THRESH(BTN_THRESH), .ACTIVE_LOW(1'b1)) u_btn_qual (
      .clk(clk), .rst(rst), .tick_i(tick_ms), .level_i(btn_s),
      .qual_o(req.btn));

   assign req.wdog = wdog_to;

   logic req_any;
   assign req_any = |req;

   logic hold_busy;
   sup_hold #(.HOLD_TICKS(HOLD_MS)) u_hold (
      .clk(clk), .rst(rst), .tick_i(tick_ms), .req_i(req_any),
      .busy_o(hold_busy));

   // Separate flops for each polarity and the status line.
   logic rst_hi_q, rst_lo_q, active_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         rst_hi_q <= 1'b1;
         rst_lo_q <= 1'b0;
         active_q <= 1'b0;
      end else begin
         rst_hi_q <= req_any | hold_busy;
         rst_lo_q <= ~(req_any | hold_busy);
         active_q <= req_any;
      end
   end

   assign sys_rst    = rst_hi_q;
   assign sys_rst_n  = rst_lo_q;
   assign rst_active = active_q;

   assert_complement_R9: assert property (@(posedge clk) disable iff (rst)
      rst_hi_q != rst_lo_q);

   assert_status_in_reset_R10: assert property (@(posedge clk) disable iff (rst)
      active_q |-> rst_hi_q);

   assert_wdog_resets_R7: assert property (@(posedge clk) disable iff (rst)
      wdog_to |=> rst_hi_q);

endmodule

// File: tb/tb_sup_reset_stretch.sv
module tb_sup_reset_stretch;

   localparam int TMS  = 16;   // clocks per millisecond tick
   localparam int TUS  = 4;    // clocks per microsecond tick
   localparam int HOLD = 250;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick_ms = 1'b0, tick_us = 1'b0;
   logic pwr_fail = 1'b1, btn_n = 1'b1, wdog_to = 1'b0;
   logic sys_rst, sys_rst_n, rst_active;

   int cyc = 0;
   int total = 0, bad = 0;
   int comp_err = 0;
   int unexpected = 0;

   always #2 clk = ~clk;   // 250 MHz

   always @(posedge clk) begin
      cyc     <= cyc + 1;
      tick_ms <= (cyc % TMS == TMS - 1);
      tick_us <= (cyc % TUS == TUS - 1);
   end

   sup_reset_stretch dut (
      .clk(clk), .rst(rst), .tick_ms(tick_ms), .tick_us(tick_us),
      .pwr_fail(pwr_fail), .btn_n(btn_n), .wdog_to(wdog_to),
      .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .rst_active(rst_active));

   typedef struct {
      int    lo;
      int    hi;
      string tag;
   } exp_t;
   exp_t sbq[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver side: the request was removed in the current cycle
   task automatic expect_release(input string tag);
      exp_t e;
      e.lo  = cyc + HOLD * TMS;
      e.hi  = cyc + (HOLD + 1) * TMS + 8;
      e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic wait_idle();
      while (sys_rst) @(negedge clk);
      repeat (5) @(negedge clk);
   endtask

   // monitor: pops one expected release per falling edge of sys_rst
   logic prev_rst = 1'b1;
   always @(negedge clk) begin
      if (sys_rst !== ~sys_rst_n) comp_err++;
      if (prev_rst && !sys_rst) begin
         if (sbq.size() == 0) begin
            unexpected++;
         end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(cyc >= e.lo && cyc <= e.hi, {e.tag, " R3 release window"}, cyc, e.lo);
         end
      end
      prev_rst = sys_rst;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      chk(sys_rst == 1'b1, "R1 rst high in reset", sys_rst, 1);
      chk(sys_rst_n == 1'b0, "R1 rst_n low in reset", sys_rst_n, 0);
      chk(rst_active == 1'b0, "R1 status low in reset", rst_active, 0);

      // power-up with supply still bad
      rst = 1'b0;
      repeat (100) @(negedge clk);
      chk(sys_rst == 1'b1, "R2 reset while power bad", sys_rst, 1);
      chk(rst_active == 1'b1, "R10 status while power bad", rst_active, 1);
      pwr_fail = 1'b0;
      expect_release("R2");
      wait_idle();
      chk(sys_rst_n == 1'b1, "R2 released after hold", sys_rst_n, 1);

      // block reset alone starts a full hold
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(sys_rst == 1'b1, "R1 rst reasserted", sys_rst, 1);
      rst = 1'b0;
      expect_release("R1");
      wait_idle();

      // 19 ms press is rejected
      btn_n = 1'b0;
      repeat (19 * TMS) @(negedge clk);
      btn_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(sys_rst == 1'b0, "R5 19ms press ignored", sys_rst, 0);

      // 21 ms press is accepted
      btn_n = 1'b0;
      repeat (21 * TMS) @(negedge clk);
      btn_n = 1'b1;
      expect_release("R5");
      repeat (20) @(negedge clk);
      chk(sys_rst == 1'b1, "R5 21ms press resets", sys_rst, 1);
      wait_idle();

      // long press: status during press and during hold
      btn_n = 1'b0;
      repeat (50 * TMS) @(negedge clk);
      chk(rst_active == 1'b1, "R10 status during press", rst_active, 1);
      chk(sys_rst == 1'b1, "R6 reset during press", sys_rst, 1);
      repeat (10 * TMS) @(negedge clk);
      btn_n = 1'b1;
      expect_release("R6");
      repeat (100) @(negedge clk);
      chk(rst_active == 1'b0, "R10 status low in hold", rst_active, 0);
      chk(sys_rst == 1'b1, "R6 reset held after release", sys_rst, 1);
      wait_idle();

      // watchdog pulse
      wdog_to = 1'b1;
      @(negedge clk);
      wdog_to = 1'b0;
      expect_release("R7");
      repeat (10) @(negedge clk);
      chk(sys_rst == 1'b1, "R7 watchdog resets", sys_rst, 1);
      wait_idle();

      // reload: second pulse inside the hold window
      wdog_to = 1'b1;
      @(negedge clk);
      wdog_to = 1'b0;
      repeat (2000) @(negedge clk);
      wdog_to = 1'b1;
      @(negedge clk);
      wdog_to = 1'b0;
      expect_release("R4");
      wait_idle();

      // 1 us glitch rejected
      pwr_fail = 1'b1;
      repeat (1 * TUS) @(negedge clk);
      pwr_fail = 1'b0;
      repeat (20) @(negedge clk);
      chk(sys_rst == 1'b0, "R8 1us glitch ignored", sys_rst, 0);

      // 3 us pulse accepted
      pwr_fail = 1'b1;
      repeat (3 * TUS) @(negedge clk);
      pwr_fail = 1'b0;
      expect_release("R8");
      repeat (20) @(negedge clk);
      chk(sys_rst == 1'b1, "R8 3us fail resets", sys_rst, 1);
      wait_idle();

      chk(sbq.size() == 0, "R3 every expected release seen", sbq.size(), 0);
      chk(unexpected == 0, "R3 no unexpected release", unexpected, 0);
      chk(comp_err == 0, "R9 outputs complementary", comp_err, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule